// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital side of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A request pulse starts a conversion. The block then selects the input, holds the sample-and-hold circuit open for a fixed sampling window, and searches for the code one bit at a time, starting from the most significant bit. Each trial code goes to an external DAC and comparator. The comparator returns a single bit that says whether the input is at or above the trial code, and the block keeps or drops the trial bit on that answer.

Every conversion takes exactly 27 ticks of the conversion clock. The ticks are split as follows:
- 6 ticks of sampling.
- Eight trials of 2 ticks each.
- 5 ticks of padding.

A select input picks the conversion clock rate. It is either the block clock itself or half of it. The half rate comes from an enable strobe, not from a derived clock, so the whole block stays on one clock. The result register changes only when a conversion ends. A one-cycle done pulse marks that moment and can serve as an interrupt.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, sample_o, trial_o and result_o are all 0.
- R2: When start_i is high and busy_o is low at a clock edge, busy_o is high from the next cycle. From that cycle mux_sel_o carries the chan_sel_i value sampled at that edge.
- R3: With clk_div_i = 0 at start, busy_o stays high for exactly 27 clock cycles.
- R4: With clk_div_i = 1 at start, each conversion tick takes two clock cycles, so busy_o stays high for exactly 54 clock cycles.
- R5: sample_o is high for the first 6 conversion ticks of a conversion (6 cycles at rate 0, 12 at rate 1) and low at all other times.
- R6: The result is the largest 8-bit code k for which the comparator reports input >= k. Trials run from bit 7 down to bit 0. Both 00h and FFh are reachable.
- R7: done_o is high for exactly one cycle. It rises in the same cycle that busy_o falls and result_o takes the new value.
- R8: result_o holds its value at all times except the completion cycle.
- R9: A start_i pulse while busy_o is high is ignored. The running conversion keeps its length and its result.
- R10: The channel and the clock rate are captured at start. Changing chan_sel_i during a conversion does not change mux_sel_o or the result.
- R11: In the first cycle after sampling ends, trial_o equals 80h, which is the first trial with only the most significant bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request |
| chan_sel_i | input | 3 | Input channel to convert |
| clk_div_i | input | 1 | Conversion clock rate: 0 = full rate, 1 = half rate |
| cmp_i | input | 1 | Comparator answer: 1 when input >= trial_o |
| mux_sel_o | output | 3 | Analog multiplexer select, captured at start |
| sample_o | output | 1 | Sample-and-hold enable |
| trial_o | output | 8 | Trial code sent to the DAC |
| busy_o | output | 1 | A conversion is in progress |
| result_o | output | 8 | Last completed conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 8 result bits, 8 channels, 6 sampling ticks, 2 settle ticks per trial and 27 ticks in total. Under these values a full-rate conversion lasts 27 cycles and a half-rate conversion lasts 54. That keeps both rates, both end codes and the neighbouring codes 01h and FEh within a short run.

During each run the bench gives every channel other than the selected one the complemented level. A wrong multiplexer select, or a channel change that leaks into a running conversion, therefore produces a different result.

// File: rtl/sar_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;

    // Phase of the conversion schedule, decoded from the tick counter.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_PAD    = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_tick_gen.sv
// Module: conversion clock enable.
// Produces a tick strobe every cycle at full rate, or every second cycle at
// half rate. Assumes restart is pulsed on the edge that accepts a start, so
// the first half-rate tick always lands two cycles after acceptance.
module sar_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic half_rate,
    output logic tick
);
    logic phase_q;

    // Phase toggle, realigned on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= 1'b0;
        else                   phase_q <= ~phase_q;
    end

    assign tick = half_rate ? phase_q : 1'b1;
endmodule

// File: rtl/sar_sched.sv
// Module: conversion schedule.
// Counts conversion ticks from the accepted start to the end of the last
// padding tick, and decodes phase, bit index and the resolve strobe.
// Assumes TOTAL_TICKS >= SAMPLE_TICKS + BITS*SETTLE_TICKS.
module sar_sched
    import sar_seq_pkg::*;
#(
    parameter int BITS         = 8,
    parameter int SAMPLE_TICKS = 6,
    parameter int SETTLE_TICKS = 2,
    parameter int TOTAL_TICKS  = 27,
    localparam int CNT_W = $clog2(TOTAL_TICKS),
    localparam int IDX_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             tick,
    output logic             active,
    output sar_phase_e       phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             resolve,
    output logic             finish
);
    localparam int TRIAL_END = SAMPLE_TICKS + BITS * SETTLE_TICKS;
    localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_TICKS);
    localparam logic [CNT_W-1:0] TEND_C   = CNT_W'(TRIAL_END);
    localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(TOTAL_TICKS - 1);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] SLAST_C  = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [CNT_W-1:0] offs;

    // Tick counter and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (launch) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q && tick) begin
            if (cnt_q == LAST_C) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Phase decode from the tick count.
    always_comb begin
        if (!active_q)              phase = PH_IDLE;
        else if (cnt_q < SAMPLE_C)  phase = PH_SAMPLE;
        else if (cnt_q < TEND_C)    phase = PH_TRIAL;
        else                        phase = PH_PAD;
    end

    assign offs    = cnt_q - SAMPLE_C;
    assign bit_idx = IDX_W'(offs / SETTLE_C);
    assign resolve = tick && (phase == PH_TRIAL) && ((offs % SETTLE_C) == SLAST_C);
    assign finish  = tick && active_q && (cnt_q == LAST_C);
    assign active  = active_q;
endmodule

// File: rtl/sar_bitreg.sv
// Module: successive-approximation register.
// Holds the bits already decided and presents the trial code with the bit
// under test set. Assumes bit_idx 0 addresses the MSB.
module sar_bitreg #(
    parameter int BITS = 8,
    localparam int IDX_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             testing,
    input  logic             resolve,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp,
    output logic [BITS-1:0]  trial,
    output logic [BITS-1:0]  code
);
    localparam logic [IDX_W-1:0] TOP_C = IDX_W'(BITS - 1);

    logic [BITS-1:0] sar_q;
    logic [BITS-1:0] mask;

    assign mask = BITS'(1) << (TOP_C - bit_idx);

    // Clear on start, keep or drop the tested bit on resolve.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sar_q <= '0;
        else if (resolve)    sar_q <= (sar_q & ~mask) | (cmp ? mask : '0);
    end

    assign trial = sar_q | (testing ? mask : '0);
    assign code  = sar_q;
endmodule

// File: rtl/sar_seq_top.sv
// Module: conversion sequencer top.
// Accepts a start when idle, captures the channel and the rate, runs the
// schedule and latches the result with a one-cycle done pulse.
// Assumes the comparator answer is valid within the settle window of a trial.
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int BITS         = 8,
    parameter int CHANNELS     = 8,
    parameter int SAMPLE_TICKS = 6,
    parameter int SETTLE_TICKS = 2,
    parameter int TOTAL_TICKS  = 27,
    localparam int CH_W  = $clog2(CHANNELS),
    localparam int IDX_W = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CH_W-1:0] chan_sel_i,
    input  logic            clk_div_i,
    input  logic            cmp_i,
    output logic [CH_W-1:0] mux_sel_o,
    output logic            sample_o,
    output logic [BITS-1:0] trial_o,
    output logic            busy_o,
    output logic [BITS-1:0] result_o,
    output logic            done_o
);
    logic             launch;
    logic             tick;
    logic             active;
    sar_phase_e       phase;
    logic [IDX_W-1:0] bit_idx;
    logic             resolve;
    logic             finish;
    logic [BITS-1:0]  code;
    logic             half_q;
    logic [CH_W-1:0]  chan_q;
    logic [BITS-1:0]  result_q;
    logic             done_q;

    assign launch = start_i && !active;

    // Capture channel and rate at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            half_q <= 1'b0;
        end else if (launch) begin
            chan_q <= chan_sel_i;
            half_q <= clk_div_i;
        end
    end

    sar_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (launch),
        .half_rate (half_q),
        .tick      (tick)
    );

    sar_sched #(
        .BITS         (BITS),
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .TOTAL_TICKS  (TOTAL_TICKS)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .tick    (tick),
        .active  (active),
        .phase   (phase),
        .bit_idx (bit_idx),
        .resolve (resolve),
        .finish  (finish)
    );

    sar_bitreg #(.BITS(BITS)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .testing (phase == PH_TRIAL),
        .resolve (resolve),
        .bit_idx (bit_idx),
        .cmp     (cmp_i),
        .trial   (trial_o),
        .code    (code)
    );

    // Result latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) result_q <= code;
        end
    end

    assign mux_sel_o = chan_q;
    assign sample_o  = (phase == PH_SAMPLE);
    assign busy_o    = active;
    assign result_o  = result_q;
    assign done_o    = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
// Module: property checker for the conversion sequencer, bound to the top.
// Assumes a synchronous active-low reset.
module sar_seq_chk #(
    parameter int BITS        = 8,
    parameter int CH_W        = 3,
    parameter int TOTAL_TICKS = 27
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            sample_o,
    input logic [BITS-1:0] result_o,
    input logic [CH_W-1:0] mux_sel_o
);
    logic [15:0] busy_len;

    // Length of the current or just-ended busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + 1'b1;
        else             busy_len <= '0;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R3
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_len == 16'(TOTAL_TICKS) || busy_len == 16'(2 * TOTAL_TICKS)));
    // R5
    sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R10
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));
endmodule

bind sar_seq_top sar_seq_chk #(
    .BITS        (BITS),
    .CH_W        (CH_W),
    .TOTAL_TICKS (TOTAL_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .sample_o  (sample_o),
    .result_o  (result_o),
    .mux_sel_o (mux_sel_o)
);

// File: tb/sar_seq_top_test.sv
// Bench: table-driven conversions, then directed reset and corner runs.
module sar_seq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 27;
    localparam int SAMPLE     = 6;
    localparam int NVEC       = 10;
    // Entry layout: {channel[2:0], half_rate, level[7:0]}; expected = level (R6)
    localparam logic [11:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 8'h00}, {3'd1, 1'b0, 8'hFF}, {3'd2, 1'b0, 8'h01},
        {3'd3, 1'b0, 8'hFE}, {3'd4, 1'b1, 8'h80}, {3'd5, 1'b1, 8'h7F},
        {3'd6, 1'b0, 8'h55}, {3'd7, 1'b1, 8'hAA}, {3'd2, 1'b1, 8'h00},
        {3'd5, 1'b1, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_sel_i = '0;
    logic       clk_div_i = 1'b0;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic       sample_o;
    logic [7:0] trial_o;
    logic       busy_o;
    logic [7:0] result_o;
    logic       done_o;
    logic [7:0] vin [8];

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural comparator: input level at or above the trial code.
    assign cmp_i = (vin[mux_sel_o] >= trial_o);

    sar_seq_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_sel_i(chan_sel_i),
        .clk_div_i(clk_div_i), .cmp_i(cmp_i), .mux_sel_o(mux_sel_o),
        .sample_o(sample_o), .trial_o(trial_o), .busy_o(busy_o),
        .result_o(result_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // mode 0: plain run, 1: extra start mid-run (R9), 2: channel change mid-run (R10)
    task automatic run_conv(input logic [2:0] ch, input logic half, input logic [7:0] lvl, input int mode);
        int nbusy = 0;
        int nsamp = 0;
        int guard = 0;
        logic prev_s = 1'b0;
        logic [7:0] first_trial = 8'h00;
        logic [7:0] held;
        for (int i = 0; i < 8; i++) vin[i] = ~lvl;
        vin[ch] = lvl;
        @(negedge clk);
        chan_sel_i = ch; clk_div_i = half; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        chk(mux_sel_o == ch, "R2 mux select", mux_sel_o, ch);
        while (!done_o && guard < 500) begin
            guard++;
            if (busy_o) nbusy++;
            if (sample_o) nsamp++;
            if (prev_s && !sample_o && busy_o) first_trial = trial_o;
            prev_s = sample_o;
            start_i = (mode == 1 && nbusy == 10);
            if (mode == 2 && nbusy == 10) chan_sel_i = ch ^ 3'd1;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(result_o == lvl, "R6 result", result_o, lvl);
        chk(nbusy == (half ? 2 * TOTAL : TOTAL), half ? "R4 half-rate length" : "R3 full-rate length",
            nbusy, half ? 2 * TOTAL : TOTAL);
        chk(nsamp == (half ? 2 * SAMPLE : SAMPLE), "R5 sampling cycles", nsamp, half ? 2 * SAMPLE : SAMPLE);
        chk(first_trial == 8'h80, "R11 first trial code", first_trial, 8'h80);
        chk(busy_o == 1'b0 && done_o == 1'b1, "R7 done with busy low", busy_o, 0);
        if (mode == 1) chk(nbusy == TOTAL * (half ? 2 : 1), "R9 restart ignored", nbusy, TOTAL);
        if (mode == 2) chk(result_o == lvl, "R10 channel change ignored", result_o, lvl);
        held = result_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done width", done_o, 0);
        repeat (5) @(negedge clk);
        chk(result_o == held, "R8 result held", result_o, held);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL R3 watchdog expired actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) vin[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && sample_o == 0, "R1 reset flags", {busy_o, done_o, sample_o}, 0);
        chk(result_o == 0 && trial_o == 0, "R1 reset data", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && result_o == 0 && trial_o == 0, "R1 after release", result_o, 0);
        for (int v = 0; v < NVEC; v++)
            run_conv(VEC[v][11:9], VEC[v][8], VEC[v][7:0], 0);
        run_conv(3'd3, 1'b0, 8'h3C, 1);
        run_conv(3'd6, 1'b1, 8'hC3, 1);
        run_conv(3'd4, 1'b0, 8'h9A, 2);
        run_conv(3'd0, 1'b1, 8'h12, 2);
        // Reset in the middle of a conversion returns to the idle state.
        @(negedge clk);
        chan_sel_i = 3'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && result_o == 0 && trial_o == 0, "R1 mid-run reset", busy_o, 0);
        rst_n = 1'b1;
        ended = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule